// File: doc/BRIEF.md
# Clipped Hebbian Weight Trainer

This block writes the binary weight matrix of an auto-associative memory with N nodes. Input and output patterns share the same width N, so the matrix is N by N. Each training pattern is given as a list of K active node indices. For every ordered pair (i, j) of those indices, including i equal to j, the trainer sets weight bit w[i][j] to 1. Bits that are already 1 are never cleared. After any number of patterns, the matrix is therefore the bitwise OR of each pattern's outer product with itself.

The matrix sits in a row-major RAM of WORD_W-bit words. Row i occupies WPR = N/WORD_W consecutive words starting at address i*WPR, and column j is bit j%WORD_W of word j/WORD_W within that row. For each row, the trainer merges all active columns that fall in one word into a single mask. It then updates that word with one read-OR-write, and words whose mask is empty are skipped.

A clear command zeroes the whole RAM before training. A second, independent read port gives the recall logic word access.

Top module: `hebb_trainer`

## Requirements
- R1: During and right after reset, busy_o and done_o are 0.
- R2: A clear command writes 0 to every RAM word (address 0 up to N*WPR-1).
- R3: After a pattern has been applied, for every pair of listed indices i and j, bit (j % WORD_W) of word i*WPR + j/WORD_W is 1. This includes the diagonal, where i equals j.
- R4: Training never clears a bit, so each bit set by an earlier pattern stays 1 after later patterns.
- R5: Training sets no bit outside the pairs of listed indices, so each word read equals the OR of the outer products of all applied patterns.
- R6: busy_o rises at the clock edge that accepts a command. It stays high through the cycle in which done_o is high. done_o is high for exactly one cycle, and busy_o is 0 in the following cycle.
- R7: While busy_o is high, start_i and clear_i are ignored: they leave the RAM contents unchanged.
- R8: An index repeated within one list has the same effect as listing it once.
- R9: rd_data_o shows the word at the address presented on rd_addr_i one clock edge earlier.
- R10: If clear_i and start_i are both high while the trainer is idle, the clear is taken and the pattern is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Zero the whole weight RAM (accepted when idle) |
| start_i | input | 1 | Apply the pattern on idx_list_i (accepted when idle) |
| idx_list_i | input | K_ACT*IDX_W | K active node indices; index k is at bits k*IDX_W and up |
| busy_o | output | 1 | A command is in progress |
| done_o | output | 1 | One-cycle pulse when the command completes |
| rd_addr_i | input | ADDR_W | Recall-side read address |
| rd_data_o | output | WORD_W | Recall-side read data, one cycle latency |

## Verification
A wrong row index, word select or column mask writes bits into the wrong word. Those bits can be seen on the read port as soon as done_o pulses, by comparing every word against an independent model of the matrix. A stale read-modify-write operand erases earlier bits, and this shows up in the dump taken after the next pattern that overlaps them. A bad sequencer state shows at once as a busy_o/done_o pulse that is missing or extra, or as a late one.

// File: rtl/hebb_pkg.sv
package hebb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLR,
    ST_SCAN,
    ST_WR,
    ST_DONE
  } hebb_state_e;
endpackage

// File: rtl/hebb_col_mask.sv
// Merges all active column indices that land in the selected word.
module hebb_col_mask #(
  parameter int N_NODES = 128,
  parameter int K_ACT   = 4,
  parameter int WORD_W  = 64,
  localparam int IDX_W  = $clog2(N_NODES),
  localparam int WPR    = N_NODES / WORD_W,
  localparam int WSEL_W = (WPR > 1) ? $clog2(WPR) : 1,
  localparam int OFF_W  = $clog2(WORD_W)
) (
  input  logic [K_ACT*IDX_W-1:0] idx_list_i,
  input  logic [WSEL_W-1:0]      word_sel_i,
  output logic [WORD_W-1:0]      mask_o
);
  logic [WORD_W-1:0] part [K_ACT];

  for (genvar k = 0; k < K_ACT; k++) begin : g_col
    logic [IDX_W-1:0] idx;
    logic             hit;
    assign idx = idx_list_i[k*IDX_W +: IDX_W];
    if (WPR > 1) begin : g_multi
      assign hit = (idx >> OFF_W) == IDX_W'(word_sel_i);
    end else begin : g_single
      logic unused_sel;
      assign unused_sel = |word_sel_i;
      assign hit = 1'b1;
    end
    assign part[k] = hit ? (WORD_W'(1) << idx[OFF_W-1:0]) : '0;
  end

  always_comb begin
    mask_o = '0;
    for (int k = 0; k < K_ACT; k++) mask_o = mask_o | part[k];
  end
endmodule

// File: rtl/hebb_weight_ram.sv
// One write port, two registered read ports (update side and recall side).
module hebb_weight_ram #(
  parameter int WORDS  = 256,
  parameter int WORD_W = 64,
  localparam int ADDR_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] ra_addr_i,
  output logic [WORD_W-1:0] ra_data_o,
  input  logic [ADDR_W-1:0] rb_addr_i,
  output logic [WORD_W-1:0] rb_data_o
);
  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    ra_data_o <= mem[ra_addr_i];
    rb_data_o <= mem[rb_addr_i];
  end
endmodule

// File: rtl/hebb_trainer.sv
module hebb_trainer #(
  parameter int N_NODES = 128,
  parameter int K_ACT   = 4,
  parameter int WORD_W  = 64,
  localparam int IDX_W  = $clog2(N_NODES),
  localparam int WPR    = N_NODES / WORD_W,
  localparam int WORDS  = N_NODES * WPR,
  localparam int ADDR_W = $clog2(WORDS),
  localparam int WSEL_W = (WPR > 1) ? $clog2(WPR) : 1,
  localparam int ROW_W  = (K_ACT > 1) ? $clog2(K_ACT) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clear_i,
  input  logic                   start_i,
  input  logic [K_ACT*IDX_W-1:0] idx_list_i,
  output logic                   busy_o,
  output logic                   done_o,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  output logic [WORD_W-1:0]      rd_data_o
);
  import hebb_pkg::*;

  hebb_state_e            state_q;
  logic [ROW_W-1:0]       row_q;
  logic [WSEL_W-1:0]      word_q;
  logic [ADDR_W-1:0]      clr_addr_q;
  logic [K_ACT*IDX_W-1:0] idx_q;

  logic [IDX_W-1:0]  row_idx;
  logic [ADDR_W-1:0] train_addr;
  logic [WORD_W-1:0] col_mask;
  logic              last_word, last_step;

  logic              ram_we;
  logic [ADDR_W-1:0] ram_waddr;
  logic [WORD_W-1:0] ram_wdata, ram_ra_data;

  assign row_idx    = idx_q[row_q*IDX_W +: IDX_W];
  assign train_addr = ADDR_W'(row_idx) * ADDR_W'(WPR) + ADDR_W'(word_q);
  assign last_word  = (word_q == WSEL_W'(WPR - 1));
  assign last_step  = last_word && (row_q == ROW_W'(K_ACT - 1));

  hebb_col_mask #(
    .N_NODES(N_NODES), .K_ACT(K_ACT), .WORD_W(WORD_W)
  ) u_mask (
    .idx_list_i(idx_q),
    .word_sel_i(word_q),
    .mask_o    (col_mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      row_q      <= '0;
      word_q     <= '0;
      clr_addr_q <= '0;
      idx_q      <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          row_q      <= '0;
          word_q     <= '0;
          clr_addr_q <= '0;
          if (clear_i) begin
            state_q <= ST_CLR;          // clear wins over start
          end else if (start_i) begin
            idx_q   <= idx_list_i;
            state_q <= ST_SCAN;
          end
        end
        ST_CLR: begin
          clr_addr_q <= clr_addr_q + 1'b1;
          if (clr_addr_q == ADDR_W'(WORDS - 1)) state_q <= ST_DONE;
        end
        ST_SCAN, ST_WR: begin
          // SCAN with a live mask issues the read; WR finishes the word.
          if (state_q == ST_SCAN && col_mask != '0) begin
            state_q <= ST_WR;
          end else if (last_step) begin
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_SCAN;
            if (last_word) begin
              word_q <= '0;
              row_q  <= row_q + 1'b1;
            end else begin
              word_q <= word_q + 1'b1;
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);

  always_comb begin
    ram_we    = (state_q == ST_CLR) || (state_q == ST_WR);
    ram_waddr = (state_q == ST_CLR) ? clr_addr_q : train_addr;
    ram_wdata = (state_q == ST_CLR) ? '0 : (ram_ra_data | col_mask);
  end

  hebb_weight_ram #(
    .WORDS(WORDS), .WORD_W(WORD_W)
  ) u_ram (
    .clk_i    (clk_i),
    .we_i     (ram_we),
    .waddr_i  (ram_waddr),
    .wdata_i  (ram_wdata),
    .ra_addr_i(train_addr),
    .ra_data_o(ram_ra_data),
    .rb_addr_i(rd_addr_i),
    .rb_data_o(rd_data_o)
  );

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);                                               // R6
  AST_DONE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);                                                // R6
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);                                   // R6
  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !ram_we);                                              // R7
  AST_TRAIN_NO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR) |-> ((ram_wdata & ram_ra_data) == ram_ra_data)); // R4
  AST_WR_LIVE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR) |-> (col_mask != '0));                          // R5
endmodule

// File: tb/hebb_trainer_tb.sv
module hebb_trainer_tb;
  localparam int N      = 128;
  localparam int K      = 4;
  localparam int W      = 64;
  localparam int IDX_W  = 7;
  localparam int WPR    = N / W;
  localparam int WORDS  = N * WPR;
  localparam int ADDR_W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic clear_i = 1'b0;
  logic start_i = 1'b0;
  logic [K*IDX_W-1:0] idx_list_i = '0;
  logic busy_o, done_o;
  logic [ADDR_W-1:0] rd_addr_i = '0;
  logic [W-1:0] rd_data_o;

  int checks = 0;
  int errors = 0;

  bit ref_m [N][N];

  logic [ADDR_W-1:0] q_addr [$];
  logic [W-1:0]      q_exp [$];
  string             q_tag [$];

  always #5 clk_i = ~clk_i;

  hebb_trainer #(.N_NODES(N), .K_ACT(K), .WORD_W(W)) u_dut (
    .clk_i, .rst_ni, .clear_i, .start_i, .idx_list_i,
    .busy_o, .done_o, .rd_addr_i, .rd_data_o
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected word per edge, 2 ns after the edge (R9 latency).
  initial forever begin
    @(posedge clk_i);
    #2;
    if (q_addr.size() > 0) begin
      logic [ADDR_W-1:0] a;
      logic [W-1:0] e;
      string t;
      a = q_addr.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      chk(rd_data_o === e, $sformatf("%s R9 word %0d", t, a), rd_data_o, e);
    end
  end

  function automatic logic [K*IDX_W-1:0] pack(input int a, input int b,
                                              input int c, input int d);
    return {IDX_W'(d), IDX_W'(c), IDX_W'(b), IDX_W'(a)};
  endfunction

  function automatic void model_train(input int a, input int b,
                                      input int c, input int d);
    int l [K];
    l = '{a, b, c, d};
    foreach (l[r]) foreach (l[s]) ref_m[l[r]][l[s]] = 1'b1;
  endfunction

  function automatic void model_clear();
    foreach (ref_m[r, s]) ref_m[r][s] = 1'b0;
  endfunction

  task automatic dump(input string tag);
    for (int a = 0; a < WORDS; a++) begin
      logic [W-1:0] e;
      for (int b = 0; b < W; b++) e[b] = ref_m[a / WPR][(a % WPR) * W + b];
      @(negedge clk_i);
      rd_addr_i = ADDR_W'(a);
      q_addr.push_back(ADDR_W'(a));
      q_exp.push_back(e);
      q_tag.push_back(tag);
    end
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wait_done(input string tag);
    do @(negedge clk_i); while (!done_o);
    @(negedge clk_i);
    chk(!busy_o && !done_o, {tag, " R6 idle after done"},
        W'({busy_o, done_o}), '0);
  endtask

  task automatic do_clear();
    @(negedge clk_i);
    clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
    chk(busy_o, "R6 busy after clear", W'(busy_o), 1);
    wait_done("clear");
    model_clear();
  endtask

  task automatic train(input int a, input int b, input int c, input int d);
    @(negedge clk_i);
    idx_list_i = pack(a, b, c, d);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o && !done_o, "R6 busy after start", W'({busy_o, done_o}), W'(2));
    wait_done("train");
    model_train(a, b, c, d);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    chk(!busy_o && !done_o, "R1 in reset", W'({busy_o, done_o}), '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o, "R1 after reset", W'({busy_o, done_o}), '0);

    do_clear();
    dump("R2 initial clear");

    train(3, 70, 10, 127);
    dump("R3 R5 first pattern");

    train(3, 5, 64, 100);
    dump("R4 R5 overlapping pattern");

    train(20, 20, 90, 20);
    dump("R8 repeated index");

    // R7: start and clear raised while the trainer is busy.
    @(negedge clk_i);
    idx_list_i = pack(40, 41, 42, 43);
    start_i = 1'b1;
    @(negedge clk_i);
    chk(busy_o, "R7 busy before ignored commands", W'(busy_o), 1);
    idx_list_i = pack(1, 2, 66, 99);
    clear_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    clear_i = 1'b0;
    wait_done("R7");
    model_train(40, 41, 42, 43);
    dump("R7 busy commands ignored");

    // R10: clear and start together while idle.
    @(negedge clk_i);
    idx_list_i = pack(7, 8, 9, 11);
    start_i = 1'b1;
    clear_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    clear_i = 1'b0;
    wait_done("R10");
    model_clear();
    dump("R10 clear wins");

    train(0, 63, 64, 127);
    train(127, 0, 1, 126);
    dump("R3 R4 word edges");

    do_clear();
    dump("R2 clear after training");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule